// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host reach a 256-entry byte register file over a four-wire synchronous serial link. The link has a chip select (active low), a shift clock, a data input, a data output and a level-sensitive direction line. Every transfer opens with one address byte. Any number of data bytes follow it, and the address steps forward after each one, so a burst covers consecutive registers and wraps from 0xFF to 0x00. Bits travel least significant first in both directions.

All serial inputs are brought into the system clock domain by synchronisers, and the block works from the edges it sees there. The host shifts a bit in on a rising shift-clock edge and the block changes its output on a falling edge. The direction line chooses the operation. When it is high, the addressed register is fetched as soon as the address byte is complete, and the block drives it out. When it is low, the output stays released and each completed data byte is written through a single-cycle strobe. Releasing chip select discards any partial byte and returns the block to the address phase.

Top module: `ser_reg_slave`

## Requirements
- R1: `sdo_oe` is 1 only while chip select is low and `rd_sel` is high, seen through the synchronisers. It returns to 0 within a few system clocks of chip select going high, and it stays 0 for a whole write transfer.
- R2: The first 8 bits shifted in after chip select falls form the register address. The first bit sampled is address bit 0.
- R3: With `rd_sel` low, each completed data byte, first bit sampled = bit 0, is written to the register at the current address.
- R4: The address rises by one after every data byte, in both directions, and wraps from 0xFF to 0x00.
- R5: With `rd_sel` high, bit 0 of the addressed register appears on `sdo` after the first falling shift-clock edge that follows the address byte. The other bits follow in rising order, one per falling edge. `sdo` changes only in response to a falling shift-clock edge.
- R6: A read transfer leaves every register unchanged, whatever bits arrive on `sdi`.
- R7: Raising chip select in the middle of a byte, in either phase, discards that byte. The next transfer starts again with an address byte.
- R8: If a byte's eighth rising edge and the release of chip select are seen in the same system clock cycle, the release wins and the byte is dropped. A byte whose eighth edge is seen earlier is written.
- R9: The internal write strobe lasts exactly one system clock per written byte. A burst of N bytes changes exactly N registers.
- R10: After reset every register reads 0x00 and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| sck | input | 1 | Serial shift clock, idles low |
| sdi | input | 1 | Serial data in, LSB first |
| rd_sel | input | 1 | 1 = read transfer, 0 = write transfer |
| sdo | output | 1 | Serial data out, LSB first |
| sdo_oe | output | 1 | Output enable for sdo; 0 means released (high impedance) |

## Verification
Completing a byte and releasing chip select can land in the same system clock cycle, because both signals pass through synchronisers of equal depth. The bench provokes this by raising the shift clock for a byte's eighth bit at the same instant that chip select rises. It then reads the target register back and expects the old value. The same sequence with chip select raised half a bit later must store the new byte. A checker property also forbids any write strobe that follows a cycle in which select was seen released.

// File: rtl/srs_pkg.sv
// Shared types for the serial register access slave.
// Assumes nothing beyond a standard SystemVerilog package scope.
package srs_pkg;
    // Transfer phase: the address byte comes first, then data bytes.
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;
endpackage

// File: rtl/srs_sync.sv
// Multi-stage synchroniser for a small vector of asynchronous inputs.
// Assumes each bit is independently meaningful (no multi-bit coherence)
// and that inputs stay stable for several clk periods between changes.
module srs_sync #(
    parameter int             N       = 1,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] chain [STAGES];

    // Shift the asynchronous vector through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srs_regfile.sv
// Byte register file with one synchronous write port and one
// combinational read port. Assumes a write and a read of the same entry
// never need to forward within one cycle.
module srs_regfile #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] rd_addr,
    output logic [W-1:0] rd_data
);
    localparam int DEPTH = 1 << W;

    logic [W-1:0] mem [DEPTH];

    // Clear on reset, otherwise store on the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/srs_frame.sv
// Frame engine: detects shift-clock edges on synchronised inputs,
// assembles LSB-first bytes, tracks address/data phase, issues write
// strobes and shifts read data out. Assumes all inputs are already in
// the clk domain and the shift clock idles low.
module srs_frame
    import srs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_q,
    input  logic                   sck_q,
    input  logic                   sdi_q,
    input  logic                   rd_q,
    input  logic [W-1:0]           rd_data,
    output logic [W-1:0]           rd_addr,
    output logic                   we,
    output logic [W-1:0]           wr_addr,
    output logic [W-1:0]           wr_data,
    output logic                   sdo,
    output logic                   sdo_oe,
    output logic                   fall_evt,
    output logic [W-1:0]           addr_q,
    output logic [$clog2(W)-1:0]   bit_cnt,
    output phase_e                 phase
);
    localparam int             CW   = $clog2(W);
    localparam logic [CW-1:0]  LAST = CW'(W - 1);
    localparam logic [W-1:0]   ONE  = W'(1);

    logic         sck_prev;
    logic         rise_evt;
    logic [W-1:0] shreg;
    logic [W-1:0] tx;
    logic [W-1:0] byte_full;

    assign rise_evt  = sck_q & ~sck_prev;
    assign fall_evt  = ~sck_q & sck_prev;
    assign byte_full = {sdi_q, shreg[W-1:1]};
    // Fetch target: the new address at the end of the address byte,
    // otherwise the next register of the burst.
    assign rd_addr   = (phase == PH_ADDR) ? byte_full : addr_q + ONE;

    // Sequence bits, bytes and phases; select release has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            shreg    <= '0;
            tx       <= '0;
            bit_cnt  <= '0;
            phase    <= PH_ADDR;
            addr_q   <= '0;
            we       <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            sdo      <= 1'b0;
            sdo_oe   <= 1'b0;
        end else begin
            sck_prev <= sck_q;
            we       <= 1'b0;
            sdo_oe   <= ~cs_q & rd_q;
            if (cs_q) begin
                bit_cnt <= '0;
                phase   <= PH_ADDR;
            end else begin
                if (rise_evt) begin
                    shreg <= byte_full;
                    if (bit_cnt == LAST) begin
                        bit_cnt <= '0;
                        tx      <= rd_data;
                        if (phase == PH_ADDR) begin
                            addr_q <= byte_full;
                            phase  <= PH_DATA;
                        end else begin
                            addr_q <= addr_q + ONE;
                            if (!rd_q) begin
                                we      <= 1'b1;
                                wr_addr <= addr_q;
                                wr_data <= byte_full;
                            end
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (fall_evt && phase == PH_DATA) begin
                    sdo <= tx[0];
                    tx  <= tx >> 1;
                end
            end
        end
    end
endmodule

// File: rtl/ser_reg_slave.sv
// Top of the serial register access slave. Synchronises the serial pins
// into clk, runs the frame engine and holds the register file.
// Assumes the shift clock is slower than clk by a wide margin (at least
// four clk periods per level) and idles low.
module ser_reg_slave
    import srs_pkg::*;
#(
    parameter int W      = 8,
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    input  logic rd_sel,
    output logic sdo,
    output logic sdo_oe
);
    localparam int CW = $clog2(W);

    logic                cs_q;
    logic [2:0]          dsync;
    logic                sck_q, sdi_q, rd_q;
    logic [W-1:0]        rd_addr, rd_data, wr_addr, wr_data, addr_q;
    logic                we, fall_evt;
    logic [CW-1:0]       bit_cnt;
    phase_e              phase;

    srs_sync #(.N(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_q)
    );

    srs_sync #(.N(3), .STAGES(SYNC_N), .RST_VAL(3'b000)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .d({rd_sel, sdi, sck}), .q(dsync)
    );

    assign {rd_q, sdi_q, sck_q} = dsync;

    srs_frame #(.W(W)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .sck_q(sck_q),
        .sdi_q(sdi_q), .rd_q(rd_q), .rd_data(rd_data), .rd_addr(rd_addr),
        .we(we), .wr_addr(wr_addr), .wr_data(wr_data), .sdo(sdo),
        .sdo_oe(sdo_oe), .fall_evt(fall_evt), .addr_q(addr_q),
        .bit_cnt(bit_cnt), .phase(phase)
    );

    srs_regfile #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/ser_reg_slave_chk.sv
// Property checker for ser_reg_slave, attached by bind below.
// Assumes the same W and SYNC_N as the instance it watches.
module ser_reg_slave_chk
    import srs_pkg::*;
#(
    parameter int W      = 8,
    parameter int SYNC_N = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 cs_q,
    input logic                 rd_q,
    input logic                 sdo,
    input logic                 sdo_oe,
    input logic                 fall_evt,
    input logic                 we,
    input logic [W-1:0]         wr_addr,
    input logic [W-1:0]         addr_q,
    input logic [$clog2(W)-1:0] bit_cnt,
    input phase_e               phase
);
    int hi_cnt;

    // Count clk cycles for which the chip-select pin has been high.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_n) hi_cnt <= 0;
        else if (hi_cnt < SYNC_N + 2) hi_cnt <= hi_cnt + 1;
    end

    p_oe_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt > SYNC_N + 1) |-> !sdo_oe);

    p_no_write_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$past(cs_q));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (addr_q == wr_addr + W'(1)));

    p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(fall_evt));

    p_no_write_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$past(rd_q));

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> (bit_cnt == '0 && phase == PH_ADDR));

    p_strobe_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);
endmodule

bind ser_reg_slave ser_reg_slave_chk #(.W(W), .SYNC_N(SYNC_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_q(cs_q), .rd_q(rd_q),
    .sdo(sdo), .sdo_oe(sdo_oe), .fall_evt(fall_evt), .we(we),
    .wr_addr(wr_addr), .addr_q(addr_q), .bit_cnt(bit_cnt), .phase(phase)
);

// File: tb/sim_ser_reg_slave.sv
// Self-checking bench: sweeps the whole register space by burst write and
// wrapped burst read, then probes aborts, the release/completion race,
// burst extent and the output enable, against a bench-side model array.
module sim_ser_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8 * CLK_PERIOD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, rd_sel = 1'b0;
    logic sdo, sdo_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] model [256];

    ser_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .rd_sel(rd_sel), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b, output logic got);
        sdi = b;
        #(HALF);
        got = sdo;
        sck = 1'b1;
        #(HALF);
        sck = 1'b0;
    endtask

    task automatic xfer_byte(input logic [7:0] b, output logic [7:0] got);
        for (int i = 0; i < 8; i++) put_bit(b[i], got[i]);
    endtask

    task automatic open_xfer(input logic rd);
        rd_sel = rd;
        #(HALF);
        cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic close_xfer();
        cs_n = 1'b1;
        #(4 * HALF);
    endtask

    task automatic write_burst(input logic [7:0] a, input int n, input int seed);
        logic [7:0] dummy;
        open_xfer(1'b0);
        xfer_byte(a, dummy);
        for (int i = 0; i < n; i++) begin
            xfer_byte(pat(i + seed), dummy);
            model[8'(a + i)] = pat(i + seed);
        end
        close_xfer();
    endtask

    task automatic read_burst(input logic [7:0] a, input int n, input string req);
        logic [7:0] got;
        open_xfer(1'b1);
        xfer_byte(a, got);
        for (int i = 0; i < n; i++) begin
            xfer_byte(8'(8'hA5 ^ i), got);
            chk(req, got, model[8'(a + i)]);
        end
        close_xfer();
    endtask

    initial begin
        logic [7:0] g;
        logic       gb;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        #(6 * CLK_PERIOD);
        rst_n = 1'b1;
        #(4 * CLK_PERIOD);

        // R10: reset state at the pins and in the registers
        chk("R10", {7'b0, sdo_oe}, 8'h00);
        open_xfer(1'b1);
        chk("R1", {7'b0, sdo_oe}, 8'h01);
        xfer_byte(8'hF8, g);
        for (int i = 0; i < 16; i++) begin
            xfer_byte(8'h3C, g);
            chk("R10", g, 8'h00);
        end
        close_xfer();
        chk("R1", {7'b0, sdo_oe}, 8'h00);

        // R1: write transfer keeps the output released
        open_xfer(1'b0);
        chk("R1", {7'b0, sdo_oe}, 8'h00);
        xfer_byte(8'h00, g);
        chk("R1", {7'b0, sdo_oe}, 8'h00);
        close_xfer();

        // R3 R2: full-space burst write from address 0 (bit order exercised)
        write_burst(8'h00, 256, 0);
        // R4 R5: wrapped burst read starting mid-space
        read_burst(8'h80, 256, "R4");
        read_burst(8'h01, 1, "R2");
        read_burst(8'h80, 1, "R5");

        // R4: write burst across the 0xFF -> 0x00 boundary
        write_burst(8'hFF, 2, 100);
        read_burst(8'hFE, 4, "R4");

        // R6: reads with noisy sdi leave the registers unchanged
        read_burst(8'h40, 4, "R6");
        read_burst(8'h40, 4, "R6");

        // R9: a 3-byte burst touches exactly three registers
        write_burst(8'h50, 3, 200);
        read_burst(8'h4E, 7, "R9");

        // R7: abort mid data byte; register keeps its value
        open_xfer(1'b0);
        xfer_byte(8'h10, g);
        for (int i = 0; i < 5; i++) put_bit(1'b1, gb);
        close_xfer();
        read_burst(8'h10, 1, "R7");

        // R7: abort mid address byte, then a fresh transfer lands correctly
        open_xfer(1'b0);
        for (int i = 0; i < 3; i++) put_bit(1'b1, gb);
        close_xfer();
        open_xfer(1'b0);
        xfer_byte(8'h20, g);
        xfer_byte(8'hC3, g);
        model[8'h20] = 8'hC3;
        close_xfer();
        read_burst(8'h1F, 3, "R7");

        // R8: eighth rising edge and select release at the same instant
        open_xfer(1'b0);
        xfer_byte(8'h30, g);
        for (int i = 0; i < 7; i++) put_bit(i[0], gb);
        sdi = 1'b1;
        #(HALF);
        sck  = 1'b1;
        cs_n = 1'b1;
        #(HALF);
        sck = 1'b0;
        #(4 * HALF);
        read_burst(8'h30, 1, "R8");

        // R8: release half a bit after the eighth edge stores the byte
        open_xfer(1'b0);
        xfer_byte(8'h31, g);
        xfer_byte(8'h5C, g);
        model[8'h31] = 8'h5C;
        close_xfer();
        read_burst(8'h30, 3, "R8");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(150000 * CLK_PERIOD);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule